// File: doc/BRIEF.md
# DRAM Address Multiplexer and Refresh Controller

This block connects a requester that issues single-location reads and writes with a 16-bit address to a dynamic RAM array of 64K locations whose address pins are only 8 bits wide. Each accepted request is split into a row half and a column half. The two halves go out one after the other on the shared address bus. The row is latched by the row-address strobe and the column by the column-address strobe. A separate active-low write line chooses between a write and a read. Write data goes out on its own bus and read data comes back on its own bus.

An internal timer requests a row refresh at a fixed interval. The interval is derived from the clock frequency so that every one of the 256 rows is visited within the 2 ms retention window. A refresh strobes only the row address, taken from an internal row counter. Refreshes and requester accesses share the array one at a time. A pending refresh holds the ready signal low, so the requester waits. An access that has already started always runs to completion before any refresh begins.

Top module: `dram_row_col_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `req_ready` is high and `rd_valid` is low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `dram_addr` carries `req_addr[7:0]` (row), with `dram_ras_n` low and `dram_cas_n` high. The following `CAS_CYCLES` cycles carry `req_addr[15:8]` (column), with both strobes low and the address held stable.
- R3: After every access and every refresh, both strobes are high for at least one precharge cycle before `dram_ras_n` falls again.
- R4: For a write (`req_write` = 1), `dram_we_n` is low through the row and column cycles and `dram_d` carries `req_wdata` while `dram_cas_n` is low. For a read, `dram_we_n` stays high.
- R5: For a read, `dram_q` is sampled at the end of the last column cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle: the precharge cycle right after `dram_cas_n` rises. Writes produce no `rd_valid`.
- R6: A refresh becomes due every GAP clock edges after reset, where GAP = floor(CLK_KHZ * WINDOW_US / (1000 * 256)). A due refresh starts on the first idle cycle.
- R7: A refresh holds `dram_ras_n` low for `REF_CYCLES` cycles with `dram_cas_n` and `dram_we_n` high and the address stable.
- R8: The refresh row starts at 0 after reset, advances by one after each refresh and wraps from 255 to 0.
- R9: `req_ready` is high only when no access or refresh is running and no refresh is due. While it is low a request waits and the bus stays unchanged by it.
- R10: A refresh never interrupts an access in progress. When a refresh is due and a request is waiting at the same idle cycle, the refresh goes first.
- R11: `dram_cas_n` is never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester has an access to issue |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Location address; low half is the row, high half the column |
| req_wdata | input | DATA_W | Data to write |
| req_ready | output | 1 | Block accepts a request on this cycle's edge |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DATA_W | Data returned by a read |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row-address strobe, active low |
| dram_cas_n | output | 1 | Column-address strobe, active low |
| dram_we_n | output | 1 | Write control, active low |
| dram_d | output | DATA_W | Data into the array |
| dram_q | input | DATA_W | Data out of the array |

## Verification
The bound checker watches the strobe rules on every cycle. It checks that the column strobe only falls under an asserted row strobe, that a precharge cycle follows each rising row strobe, and that address and write line hold still through column cycles and row-only refresh cycles. It also checks that ready is only offered on a quiet bus and that read-valid is a single pulse right after the column strobe rises. The refresh spacing, the row counter and its wrap, the rule that a due refresh beats a waiting request, and the returned data values can only be shown by the bench's scenarios. These run against the bench's reference schedule and a behavioural array model over more than 256 refresh intervals of mixed traffic.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_REF,
      ST_PRE
   } seq_state_t;

   // Cycles between refresh requests so that all rows fit inside the window.
   function automatic int refresh_gap(input int clk_khz, input int win_us, input int rows);
      longint num;
      longint den;
      num = longint'(clk_khz) * longint'(win_us);
      den = longint'(1000) * longint'(rows);
      return int'(num / den);
   endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int GAP   = 1562,
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_grant,
   input  logic             ref_done,
   output logic             ref_pending,
   output logic [ROW_W-1:0] ref_row
);

   localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 1);

   logic [CNT_W-1:0] tick_cnt;
   logic             tick_fire;

   assign tick_fire = (tick_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= RELOAD;
      end else if (tick_fire) begin
         tick_cnt <= RELOAD;
      end else begin
         tick_cnt <= tick_cnt - 1'b1;
      end
   end

   // A new due refresh wins over the clear from a grant on the same edge.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_pending <= 1'b0;
      end else if (tick_fire) begin
         ref_pending <= 1'b1;
      end else if (ref_grant) begin
         ref_pending <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_row <= '0;
      end else if (ref_done) begin
         ref_row <= ref_row + 1'b1;
      end
   end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int CAS_CYCLES = 2,
   parameter int REF_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       ref_pending,
   output seq_state_t state,
   output logic       req_ready,
   output logic       acc_start,
   output logic       ref_grant,
   output logic       ref_done,
   output logic       cap_now
);

   localparam int MAXC = (CAS_CYCLES > REF_CYCLES) ? CAS_CYCLES : REF_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] CAS_LOAD = CW'(CAS_CYCLES - 1);
   localparam logic [CW-1:0] REF_LOAD = CW'(REF_CYCLES - 1);

   seq_state_t state_nx;
   logic [CW-1:0] hold_cnt;
   logic [CW-1:0] hold_nx;
   logic          hold_zero;

   assign hold_zero = (hold_cnt == '0);
   assign req_ready = (state == ST_IDLE) && !ref_pending;
   assign acc_start = req_ready && req_valid;
   assign ref_grant = (state == ST_IDLE) && ref_pending;
   assign ref_done  = (state == ST_REF) && hold_zero;
   assign cap_now   = (state == ST_COL) && hold_zero;

   always_comb begin
      state_nx = state;
      hold_nx  = hold_cnt;
      unique case (state)
         ST_IDLE: begin
            if (ref_pending) begin
               state_nx = ST_REF;
               hold_nx  = REF_LOAD;
            end else if (req_valid) begin
               state_nx = ST_ROW;
            end
         end
         ST_ROW: begin
            state_nx = ST_COL;
            hold_nx  = CAS_LOAD;
         end
         ST_COL, ST_REF: begin
            if (hold_zero) begin
               state_nx = ST_PRE;
            end else begin
               hold_nx = hold_cnt - 1'b1;
            end
         end
         ST_PRE: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hold_cnt <= '0;
      end else begin
         state    <= state_nx;
         hold_cnt <= hold_nx;
      end
   end

endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit ROW_LOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  seq_state_t          state,
   input  logic                acc_start,
   input  logic                cap_now,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_write,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [ADDR_W/2-1:0] ref_row,
   input  logic [DATA_W-1:0]   dram_q,
   output logic [ADDR_W/2-1:0] dram_addr,
   output logic                dram_ras_n,
   output logic                dram_cas_n,
   output logic                dram_we_n,
   output logic [DATA_W-1:0]   dram_d,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int HALF_W = ADDR_W / 2;

   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [DATA_W-1:0] wd_q;
   logic [HALF_W-1:0] row_part;
   logic [HALF_W-1:0] col_part;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         wr_q   <= 1'b0;
         wd_q   <= '0;
      end else if (acc_start) begin
         addr_q <= req_addr;
         wr_q   <= req_write;
         wd_q   <= req_wdata;
      end
   end

   generate
      if (ROW_LOW) begin : g_row_low
         assign row_part = addr_q[HALF_W-1:0];
         assign col_part = addr_q[ADDR_W-1:HALF_W];
      end else begin : g_row_high
         assign row_part = addr_q[ADDR_W-1:HALF_W];
         assign col_part = addr_q[HALF_W-1:0];
      end
   endgenerate

   always_comb begin
      dram_addr  = row_part;
      dram_ras_n = 1'b1;
      dram_cas_n = 1'b1;
      dram_we_n  = 1'b1;
      unique case (state)
         ST_ROW: begin
            dram_ras_n = 1'b0;
            dram_we_n  = !wr_q;
         end
         ST_COL: begin
            dram_addr  = col_part;
            dram_ras_n = 1'b0;
            dram_cas_n = 1'b0;
            dram_we_n  = !wr_q;
         end
         ST_REF: begin
            dram_addr  = ref_row;
            dram_ras_n = 1'b0;
         end
         default: ;
      endcase
   end

   assign dram_d = wd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap_now && !wr_q;
         if (cap_now && !wr_q) begin
            rd_data <= dram_q;
         end
      end
   end

endmodule

// File: rtl/dram_row_col_sequencer.sv
module dram_row_col_sequencer
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CLK_KHZ    = 200000,
   parameter int WINDOW_US  = 2000,
   parameter int CAS_CYCLES = 2,
   parameter int REF_CYCLES = 2,
   parameter bit ROW_LOW    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic [ADDR_W/2-1:0] dram_addr,
   output logic                dram_ras_n,
   output logic                dram_cas_n,
   output logic                dram_we_n,
   output logic [DATA_W-1:0]   dram_d,
   input  logic [DATA_W-1:0]   dram_q
);

   localparam int HALF_W = ADDR_W / 2;
   localparam int ROWS   = 1 << HALF_W;
   localparam int GAP    = refresh_gap(CLK_KHZ, WINDOW_US, ROWS);

   generate
      if ((ADDR_W % 2) != 0 || ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be positive");
      end
      if (CAS_CYCLES < 1 || REF_CYCLES < 1) begin : g_bad_hold
         $error("CAS_CYCLES and REF_CYCLES must be at least 1");
      end
      if (GAP <= CAS_CYCLES + REF_CYCLES + 4) begin : g_bad_gap
         $error("refresh interval too short for one access plus one refresh");
      end
   endgenerate

   seq_state_t         state;
   logic               acc_start;
   logic               ref_grant;
   logic               ref_done;
   logic               cap_now;
   logic               ref_pending;
   logic [HALF_W-1:0]  ref_row;

   dram_refresh_timer #(
      .GAP   (GAP),
      .ROW_W (HALF_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_grant   (ref_grant),
      .ref_done    (ref_done),
      .ref_pending (ref_pending),
      .ref_row     (ref_row)
   );

   dram_seq_fsm #(
      .CAS_CYCLES (CAS_CYCLES),
      .REF_CYCLES (REF_CYCLES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .ref_pending (ref_pending),
      .state       (state),
      .req_ready   (req_ready),
      .acc_start   (acc_start),
      .ref_grant   (ref_grant),
      .ref_done    (ref_done),
      .cap_now     (cap_now)
   );

   dram_addr_path #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .ROW_LOW (ROW_LOW)
   ) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .acc_start  (acc_start),
      .cap_now    (cap_now),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_wdata  (req_wdata),
      .ref_row    (ref_row),
      .dram_q     (dram_q),
      .dram_addr  (dram_addr),
      .dram_ras_n (dram_ras_n),
      .dram_cas_n (dram_cas_n),
      .dram_we_n  (dram_we_n),
      .dram_d     (dram_d),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
   parameter int HALF_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              ready,
   input logic              rd_valid,
   input logic [HALF_W-1:0] addr
);

   assert_cas_under_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_ready_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ras_n && cas_n));

   assert_precharge_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |=> ras_n);

   assert_rd_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_rd_after_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (cas_n && $past(!cas_n)));

   assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(!cas_n)) |-> ($stable(addr) && $stable(we_n)));

   assert_ras_only_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n) && cas_n) |-> (we_n && $stable(addr)));

endmodule

bind dram_row_col_sequencer dram_seq_checker #(.HALF_W(HALF_W)) u_seq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_n    (dram_ras_n),
   .cas_n    (dram_cas_n),
   .we_n     (dram_we_n),
   .ready    (req_ready),
   .rd_valid (rd_valid),
   .addr     (dram_addr)
);

// File: tb/test_dram_row_col_sequencer.sv
`timescale 1ns/1ps
module test_dram_row_col_sequencer;

   localparam int CLK_KHZ = 200000;
   localparam int WIN_US  = 40;
   localparam int CASN    = 2;
   localparam int REFN    = 2;
   localparam int GAP     = (CLK_KHZ * WIN_US) / (1000 * 256);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_ready;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic [7:0] dram_addr;
   logic       dram_ras_n;
   logic       dram_cas_n;
   logic       dram_we_n;
   logic [7:0] dram_d;
   logic [7:0] dram_q;

   always #2.5 clk = ~clk;

   dram_row_col_sequencer #(
      .ADDR_W(16), .DATA_W(8), .CLK_KHZ(CLK_KHZ), .WINDOW_US(WIN_US),
      .CAS_CYCLES(CASN), .REF_CYCLES(REFN), .ROW_LOW(1'b1)
   ) i_dram_row_col_sequencer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_d(dram_d), .dram_q(dram_q)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural array ----------------
   logic [7:0] cells [int];
   logic [7:0] lat_row = '0;
   logic [7:0] lat_col = '0;
   bit ras_prev = 1'b1;
   bit cas_prev = 1'b1;
   logic [7:0] q_drv = '0;
   assign dram_q = q_drv;

   always @(negedge clk) begin
      if (!dram_ras_n && ras_prev) lat_row = dram_addr;
      if (!dram_cas_n && cas_prev) begin
         lat_col = dram_addr;
         if (!dram_we_n) cells[int'({lat_col, lat_row})] = dram_d;
      end
      if (!dram_cas_n && cells.exists(int'({lat_col, lat_row})))
         q_drv = cells[int'({lat_col, lat_row})];
      else
         q_drv = 8'h00;
      ras_prev = dram_ras_n;
      cas_prev = dram_cas_n;
   end

   // ---------------- reference schedule ----------------
   typedef struct {
      logic       ras_n;
      logic       cas_n;
      logic       we_n;
      logic [7:0] addr;
      bit         chk_addr;
      bit         chk_d;
      logic [7:0] d;
      bit         cap;
      logic [7:0] rdata;
      string      rtag;
      string      atag;
   } beat_t;

   beat_t sched[$];
   logic [7:0] shadow [int];
   bit   pend = 0;
   int   edges = 0;
   int   mrow = 0;
   bit   exp_rv = 0;
   logic [7:0] exp_rd = '0;
   int   refreshes = 0;
   beat_t cur;
   bit   busy;

   function automatic beat_t mk(input logic r, input logic c, input logic w,
                                input logic [7:0] a, input bit ca, input string rt, input string at);
      beat_t b;
      b.ras_n = r; b.cas_n = c; b.we_n = w; b.addr = a; b.chk_addr = ca;
      b.chk_d = 0; b.d = '0; b.cap = 0; b.rdata = '0; b.rtag = rt; b.atag = at;
      return b;
   endfunction

   task automatic push_access(input bit w, input logic [15:0] a, input logic [7:0] d);
      beat_t b;
      logic [7:0] old;
      old = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      sched.push_back(mk(1'b0, 1'b1, !w, a[7:0], 1, "R2", "R2"));
      for (int k = 0; k < CASN; k++) begin
         b = mk(1'b0, 1'b0, !w, a[15:8], 1, "R2", "R2");
         b.chk_d = w; b.d = d;
         b.cap = (k == CASN - 1) && !w;
         b.rdata = old;
         sched.push_back(b);
      end
      sched.push_back(mk(1'b1, 1'b1, 1'b1, '0, 0, "R3", "R3"));
      if (w) shadow[int'(a)] = d;
   endtask

   task automatic push_refresh();
      for (int k = 0; k < REFN; k++)
         sched.push_back(mk(1'b0, 1'b1, 1'b1, 8'(mrow), 1, "R7", "R8"));
      sched.push_back(mk(1'b1, 1'b1, 1'b1, '0, 0, "R3", "R3"));
      mrow = (mrow + 1) % 256;
      refreshes++;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         sched.delete();
         pend = 0; edges = 0; mrow = 0; exp_rv = 0; exp_rd = '0;
      end else begin
         busy = (sched.size() > 0);
         cur = busy ? sched[0] : mk(1'b1, 1'b1, 1'b1, '0, 0, "R6", "R6");
         check(dram_ras_n === cur.ras_n, cur.rtag, "ras_n", 32'(dram_ras_n), 32'(cur.ras_n));
         check(dram_cas_n === cur.cas_n, cur.rtag, "cas_n", 32'(dram_cas_n), 32'(cur.cas_n));
         check(dram_we_n === cur.we_n, "R4", "we_n", 32'(dram_we_n), 32'(cur.we_n));
         check(req_ready === (!busy && !pend), busy ? "R10" : "R9", "req_ready",
               32'(req_ready), 32'(!busy && !pend));
         check(rd_valid === exp_rv, "R5", "rd_valid", 32'(rd_valid), 32'(exp_rv));
         if (exp_rv) check(rd_data === exp_rd, "R5", "rd_data", 32'(rd_data), 32'(exp_rd));
         if (cur.chk_addr) check(dram_addr === cur.addr, cur.atag, "dram_addr",
                                 32'(dram_addr), 32'(cur.addr));
         if (cur.chk_d) check(dram_d === cur.d, "R4", "dram_d", 32'(dram_d), 32'(cur.d));
         // advance to what the next edge produces
         if (busy) begin
            void'(sched.pop_front());
            exp_rv = cur.cap;
            exp_rd = cur.rdata;
         end else begin
            exp_rv = 0;
            if (pend) begin
               push_refresh();
               pend = 0;
            end else if (req_valid) begin
               push_access(req_write, req_addr, req_wdata);
            end
         end
         edges++;
         if (edges % GAP == 0) pend = 1;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_access(input bit w, input logic [15:0] a, input logic [7:0] d,
                            input bit wait_rd, output logic [7:0] got);
      got = '0;
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (wait_rd) begin
         forever begin
            @(negedge clk);
            if (rd_valid) break;
         end
         got = rd_data;
      end
   endtask

   logic [7:0] got;

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes in reset",
            {29'b0, dram_ras_n, dram_cas_n, dram_we_n}, 32'h7);
      check(req_ready === 1'b1 && rd_valid === 1'b0, "R1", "ready/rd_valid in reset",
            {30'b0, req_ready, rd_valid}, 32'h2);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n && req_ready && !rd_valid, "R1",
            "state after reset", {27'b0, dram_ras_n, dram_cas_n, dram_we_n, req_ready, rd_valid},
            32'h1e);

      // R2/R4: writes at corner addresses, row from low byte, column from high byte
      do_access(1, 16'h0000, 8'hA5, 0, got);
      do_access(1, 16'hFFFF, 8'h3C, 0, got);
      do_access(1, 16'h12AB, 8'hE7, 0, got);
      do_access(1, 16'hAB12, 8'h18, 0, got);
      // R5: read back, halves must not be swapped
      do_access(0, 16'h12AB, 8'h00, 1, got);
      check(got === 8'hE7, "R5", "readback 12AB", 32'(got), 32'hE7);
      do_access(0, 16'hAB12, 8'h00, 1, got);
      check(got === 8'h18, "R5", "readback AB12", 32'(got), 32'h18);
      do_access(0, 16'h0000, 8'h00, 1, got);
      check(got === 8'hA5, "R5", "readback 0000", 32'(got), 32'hA5);
      do_access(0, 16'hFFFF, 8'h00, 1, got);
      check(got === 8'h3C, "R5", "readback FFFF", 32'(got), 32'h3C);

      // R6..R10: sustained mixed traffic across more than 256 refresh intervals
      for (int i = 0; i < 1400; i++) begin
         do_access((i % 3) != 2, 16'(i * 7919 + 13), 8'(i * 37 + 5), 0, got);
         if (i % 11 == 0) repeat (3) @(posedge clk);
      end
      repeat (GAP + 10) @(posedge clk);
      check(refreshes > 256, "R8", "refresh count covers row wrap", 32'(refreshes), 32'd257);

      do_access(0, 16'h12AB, 8'h00, 1, got);
      check(got === shadow[int'(16'h12AB)], "R10", "data kept across refreshes",
            32'(got), 32'(shadow[int'(16'h12AB)]));

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule